// File: doc/BRIEF.md
# Four-Channel Down-Counter and Timestamp Timer

The block holds three reloadable down-counters and one free-running timestamp counter behind a small 32-bit word-addressed register bus. Two of the down-counters are 16 bits wide and the third is 32 bits wide. Each one counts on a tick strobe that its own control register selects: either the slow tick (`slow_tick_i`) or the fast tick (`fast_tick_i`). When a down-counter underflows, it either reloads from its load register (periodic mode) or wraps to all ones (free mode). In both modes it raises a level interrupt, and that interrupt stays high until software writes the channel's clear register.

The timestamp channel is a 40-bit up-counter that advances on the fast tick only. It never interrupts. Software reads its low 32 bits from one register, and its top 8 bits together with its enable flag from a second register. A typical driver uses one 16-bit channel in periodic mode as the system tick interrupt. It then uses the timestamp to measure the time elapsed between interrupts. Both tick rates are generated outside the block and arrive as single-cycle enable strobes.

Top module: `timer_bank`

## Requirements
- R1: After reset, every counter, load register, control register and interrupt is zero, and the timestamp is stopped at zero.
- R2: Register words are selected by `bus_addr_i`. For channel c in 0..2, word 4c is load, 4c+1 is value (read only), 4c+2 is control and 4c+3 is clear (write only, reads zero). Word 12 is timestamp low and word 13 is timestamp high; all other words read zero. A write to a load word stores the value in the load register and also in the counter in that same cycle, whether or not the channel is enabled.
- R3: A channel counts only while control bit 7 (enable) is set. It decrements by one on each tick of its selected source: control bit 3 = 1 selects `slow_tick_i` and 0 selects `fast_tick_i`. Ticks from the other source and ticks while disabled leave the counter unchanged.
- R4: With control bit 6 set (periodic), a tick at zero reloads the load value, so a load value of N gives one underflow every N+1 selected ticks.
- R5: With control bit 6 clear (free), a tick at zero wraps the counter to all ones of the channel's width.
- R6: Every underflow sets `irq_o[c]`, which stays high until a write of any data to the channel's clear word. A clear write in the same cycle as an underflow leaves the interrupt high.
- R7: Channels 0 and 1 are 16 bits wide and channel 2 is 32 bits wide. Load-write bits above the width are dropped, and load and value reads are zero-extended.
- R8: Bit 8 of a timestamp-high write sets the timestamp enable. While enabled, the 40-bit count increments on each `fast_tick_i`. Word 12 reads count bits 31:0. Word 13 reads count bits 39:32 in bits 7:0 and the enable in bit 8. A high write with bit 8 clear stops the count and zeroes it.
- R9: The timestamp ignores `slow_tick_i` and drives no interrupt. Writes to word 12 and to any value word change nothing.
- R10: A control read returns bits 7, 6 and 3 as last written, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_tick_i | input | 1 | Slow count enable strobe |
| fast_tick_i | input | 1 | Fast count enable strobe |
| bus_req_i | input | 1 | Bus access valid |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 4 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 3 | Underflow interrupt per reloadable channel |

## Verification
Directed patterns cover several cases. Load 4 under a continuous slow tick shows an N+1 period, which separates that from N or N+2. A load of 0 in free mode separates wrap-to-all-ones from reload on both the 16-bit and the 32-bit channel. Alternating slow-only and fast-only ticks shows that the tick-source bit is decoded the right way round, and a clear written in the very cycle a zero count underflows checks the priority rule. A long seeded random mix of ticks, small load values, control words, clears and timestamp enables then runs against a bench model, comparing the interrupts every cycle and one random register read per cycle.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 4;
  localparam int NUM_RLD = 3;

  localparam int OFS_LOAD  = 0;
  localparam int OFS_VALUE = 1;
  localparam int OFS_CTRL  = 2;
  localparam int OFS_CLEAR = 3;
  localparam int ADDR_STAMP_LO = 12;
  localparam int ADDR_STAMP_HI = 13;

  localparam int CTRL_EN_BIT  = 7;
  localparam int CTRL_PER_BIT = 6;
  localparam int CTRL_SRC_BIT = 3;
  localparam int STAMP_EN_BIT = 8;

  typedef struct packed {
    logic en;
    logic periodic;
    logic slow_src;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] ctrl_word(ctrl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CTRL_EN_BIT]  = c.en;
    w[CTRL_PER_BIT] = c.periodic;
    w[CTRL_SRC_BIT] = c.slow_src;
    return w;
  endfunction
endpackage

// File: rtl/timer_regif.sv
module timer_regif
  import timer_bank_pkg::*;
(
  input  logic                            req_i,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  output logic [NUM_RLD-1:0]              load_we_o,
  output logic [NUM_RLD-1:0]              ctrl_we_o,
  output logic [NUM_RLD-1:0]              clr_we_o,
  output logic                            stamp_hi_we_o,
  input  logic [NUM_RLD-1:0][DATA_W-1:0]  rd_load_i,
  input  logic [NUM_RLD-1:0][DATA_W-1:0]  rd_cnt_i,
  input  ctrl_t [NUM_RLD-1:0]             rd_ctrl_i,
  input  logic [DATA_W-1:0]               stamp_lo_i,
  input  logic [DATA_W-1:0]               stamp_hi_i,
  output logic [DATA_W-1:0]               rdata_o
);
  logic wr;
  assign wr = req_i & we_i;

  always_comb begin
    for (int c = 0; c < NUM_RLD; c++) begin
      load_we_o[c] = wr && (addr_i == ADDR_W'(4*c + OFS_LOAD));
      ctrl_we_o[c] = wr && (addr_i == ADDR_W'(4*c + OFS_CTRL));
      clr_we_o[c]  = wr && (addr_i == ADDR_W'(4*c + OFS_CLEAR));
    end
    stamp_hi_we_o = wr && (addr_i == ADDR_W'(ADDR_STAMP_HI));
  end

  // Read mux: clear words and unmapped words return zero
  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_RLD; c++) begin
      if (addr_i == ADDR_W'(4*c + OFS_LOAD))  rdata_o = rd_load_i[c];
      if (addr_i == ADDR_W'(4*c + OFS_VALUE)) rdata_o = rd_cnt_i[c];
      if (addr_i == ADDR_W'(4*c + OFS_CTRL))  rdata_o = ctrl_word(rd_ctrl_i[c]);
    end
    if (addr_i == ADDR_W'(ADDR_STAMP_LO)) rdata_o = stamp_lo_i;
    if (addr_i == ADDR_W'(ADDR_STAMP_HI)) rdata_o = stamp_hi_i;
  end
endmodule

// File: rtl/timer_reload_ch.sv
module timer_reload_ch
  import timer_bank_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         slow_tick_i,
  input  logic         fast_tick_i,
  input  logic         load_we_i,
  input  logic [W-1:0] load_data_i,
  input  logic         ctrl_we_i,
  input  ctrl_t        ctrl_i,
  input  logic         clr_we_i,
  output logic [W-1:0] load_o,
  output logic [W-1:0] cnt_o,
  output ctrl_t        ctrl_o,
  output logic         irq_o
);
  logic [W-1:0] load_q, cnt_q;
  ctrl_t        ctrl_q;
  logic         irq_q;
  logic         tick_sel, step, at_zero, underflow;

  assign tick_sel  = ctrl_q.slow_src ? slow_tick_i : fast_tick_i;
  assign step      = ctrl_q.en & tick_sel;
  assign at_zero   = (cnt_q == '0);
  assign underflow = step & at_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '0;
      cnt_q  <= '0;
    end else if (load_we_i) begin
      load_q <= load_data_i;
      cnt_q  <= load_data_i;
    end else if (step) begin
      if (at_zero) cnt_q <= ctrl_q.periodic ? load_q : '1;
      else         cnt_q <= cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_i;
  end

  // Underflow beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         irq_q <= 1'b0;
    else if (underflow)  irq_q <= 1'b1;
    else if (clr_we_i)   irq_q <= 1'b0;
  end

  assign load_o = load_q;
  assign cnt_o  = cnt_q;
  assign ctrl_o = ctrl_q;
  assign irq_o  = irq_q;

  p_load_now_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_we_i |=> (cnt_q == $past(load_data_i)) && (load_q == $past(load_data_i)));
  p_count_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.en && tick_sel && cnt_q != '0 && !load_we_i) |=> cnt_q == W'($past(cnt_q) - W'(1)));
  p_hold_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.en && !load_we_i) |=> $stable(cnt_q));
  p_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.en && ctrl_q.periodic && tick_sel && cnt_q == '0 && !load_we_i) |=> cnt_q == $past(load_q));
  p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.en && !ctrl_q.periodic && tick_sel && cnt_q == '0 && !load_we_i) |=> &cnt_q);
  p_irq_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.en && tick_sel && cnt_q == '0) |=> irq_q);
  p_irq_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !clr_we_i) |=> irq_q);
endmodule

// File: rtl/timer_stamp_ch.sv
module timer_stamp_ch
  import timer_bank_pkg::*;
#(
  parameter int W = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fast_tick_i,
  input  logic              hi_we_i,
  input  logic              hi_en_i,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] hi_o
);
  localparam int HI_W = W - DATA_W;

  logic [W-1:0] cnt_q;
  logic         en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (hi_we_i) en_q <= hi_en_i;
      if (hi_we_i && !hi_en_i)    cnt_q <= '0;
      else if (en_q && fast_tick_i) cnt_q <= cnt_q + W'(1);
    end
  end

  assign lo_o = cnt_q[DATA_W-1:0];

  always_comb begin
    hi_o = '0;
    hi_o[HI_W-1:0]     = cnt_q[W-1:DATA_W];
    hi_o[STAMP_EN_BIT] = en_q;
  end

  p_stamp_inc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && fast_tick_i && !hi_we_i) |=> cnt_q == W'($past(cnt_q) + W'(1)));
  p_stamp_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_we_i && !hi_en_i) |=> (cnt_q == '0) && !en_q);
  p_stamp_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fast_tick_i && !hi_we_i) |=> $stable(cnt_q));
endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import timer_bank_pkg::*;
#(
  parameter int CH0_W   = 16,
  parameter int CH1_W   = 16,
  parameter int CH2_W   = 32,
  parameter int STAMP_W = 40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               slow_tick_i,
  input  logic               fast_tick_i,
  input  logic               bus_req_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic [NUM_RLD-1:0] irq_o
);
  logic [NUM_RLD-1:0]             load_we, ctrl_we, clr_we;
  logic                           stamp_hi_we;
  logic [NUM_RLD-1:0][DATA_W-1:0] rd_load, rd_cnt;
  ctrl_t [NUM_RLD-1:0]            rd_ctrl;
  logic [DATA_W-1:0]              stamp_lo, stamp_hi;
  ctrl_t                          ctrl_wr;

  assign ctrl_wr = '{en:       bus_wdata_i[CTRL_EN_BIT],
                     periodic: bus_wdata_i[CTRL_PER_BIT],
                     slow_src: bus_wdata_i[CTRL_SRC_BIT]};

  timer_regif u_regif (
    .req_i         (bus_req_i),
    .we_i          (bus_we_i),
    .addr_i        (bus_addr_i),
    .load_we_o     (load_we),
    .ctrl_we_o     (ctrl_we),
    .clr_we_o      (clr_we),
    .stamp_hi_we_o (stamp_hi_we),
    .rd_load_i     (rd_load),
    .rd_cnt_i      (rd_cnt),
    .rd_ctrl_i     (rd_ctrl),
    .stamp_lo_i    (stamp_lo),
    .stamp_hi_i    (stamp_hi),
    .rdata_o       (bus_rdata_o)
  );

  for (genvar g = 0; g < NUM_RLD; g++) begin : g_rld
    localparam int W = (g == 0) ? CH0_W : ((g == 1) ? CH1_W : CH2_W);
    logic [W-1:0] load_w, cnt_w;

    timer_reload_ch #(.W(W)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .slow_tick_i (slow_tick_i),
      .fast_tick_i (fast_tick_i),
      .load_we_i   (load_we[g]),
      .load_data_i (bus_wdata_i[W-1:0]),
      .ctrl_we_i   (ctrl_we[g]),
      .ctrl_i      (ctrl_wr),
      .clr_we_i    (clr_we[g]),
      .load_o      (load_w),
      .cnt_o       (cnt_w),
      .ctrl_o      (rd_ctrl[g]),
      .irq_o       (irq_o[g])
    );

    assign rd_load[g] = DATA_W'(load_w);
    assign rd_cnt[g]  = DATA_W'(cnt_w);
  end

  timer_stamp_ch #(.W(STAMP_W)) u_stamp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fast_tick_i (fast_tick_i),
    .hi_we_i     (stamp_hi_we),
    .hi_en_i     (bus_wdata_i[STAMP_EN_BIT]),
    .lo_o        (stamp_lo),
    .hi_o        (stamp_hi)
  );
endmodule

// File: tb/tb_timer_bank.sv
`timescale 1ns/1ps
module tb_timer_bank;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        slow_tick_i, fast_tick_i;
  logic        bus_req_i, bus_we_i;
  logic [3:0]  bus_addr_i;
  logic [31:0] bus_wdata_i;
  logic [31:0] bus_rdata_o;
  logic [2:0]  irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench model
  logic [31:0] m_cnt [3];
  logic [31:0] m_load[3];
  logic [7:0]  m_ctrl[3];
  logic        m_irq [3];
  logic [39:0] m_st;
  logic        m_sten;

  always #2.5 clk = ~clk;

  timer_bank dut (
    .clk_i(clk), .rst_ni(rst_ni), .slow_tick_i(slow_tick_i), .fast_tick_i(fast_tick_i),
    .bus_req_i(bus_req_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  function automatic logic [31:0] mask(int c);
    return (c == 2) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic logic [31:0] exp_read(logic [3:0] a);
    int c;
    c = int'(a) / 4;
    if (a < 4'd12) begin
      case (a % 4)
        0: return m_load[c];
        1: return m_cnt[c];
        2: return {24'h0, m_ctrl[c]};
        default: return 32'h0;
      endcase
    end
    if (a == 4'd12) return m_st[31:0];
    if (a == 4'd13) return {23'h0, m_sten, m_st[39:32]};
    return 32'h0;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    bus_addr_i = a;
    #0.1;
    chk(bus_rdata_o, exp_read(a), tag);
  endtask

  task automatic chk_irq(input string tag);
    chk({29'h0, irq_o}, {29'h0, m_irq[2], m_irq[1], m_irq[0]}, tag);
  endtask

  task automatic step(input logic rq, input logic we, input logic [3:0] a,
                      input logic [31:0] d, input logic s, input logic f);
    logic wr, tk, en, uf;
    @(negedge clk);
    bus_req_i = rq; bus_we_i = we; bus_addr_i = a; bus_wdata_i = d;
    slow_tick_i = s; fast_tick_i = f;
    @(posedge clk);
    #1;
    wr = rq && we;
    for (int c = 0; c < 3; c++) begin
      tk = m_ctrl[c][3] ? s : f;
      en = m_ctrl[c][7];
      uf = en && tk && (m_cnt[c] == 32'h0);
      if (wr && a == 4'(4*c)) begin
        m_load[c] = d & mask(c);
        m_cnt[c]  = d & mask(c);
      end else if (en && tk) begin
        if (m_cnt[c] == 32'h0) m_cnt[c] = m_ctrl[c][6] ? m_load[c] : mask(c);
        else                   m_cnt[c] = m_cnt[c] - 32'h1;
      end
      if (wr && a == 4'(4*c + 2)) m_ctrl[c] = d[7:0] & 8'hC8;
      if (uf) m_irq[c] = 1'b1;
      else if (wr && a == 4'(4*c + 3)) m_irq[c] = 1'b0;
    end
    if (wr && a == 4'd13 && !d[8]) m_st = 40'h0;
    else if (m_sten && f)          m_st = m_st + 40'h1;
    if (wr && a == 4'd13) m_sten = d[8];
    bus_req_i = 1'b0; bus_we_i = 1'b0; slow_tick_i = 1'b0; fast_tick_i = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    step(1'b1, 1'b1, a, d, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [3:0]  a;
    for (int c = 0; c < 3; c++) begin
      m_cnt[c] = '0; m_load[c] = '0; m_ctrl[c] = '0; m_irq[c] = 1'b0;
    end
    m_st = '0; m_sten = 1'b0;
    rst_ni = 1'b0; slow_tick_i = 0; fast_tick_i = 0;
    bus_req_i = 0; bus_we_i = 0; bus_addr_i = 0; bus_wdata_i = 0;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1 reset state
    chk({29'h0, irq_o}, 32'h0, "R1 irq");
    for (int i = 0; i < 14; i++) rd(4'(i), "R1 reset read");

    // R2, R10: setup then load, periodic start
    wr(4'd2, 32'h48);
    rd(4'd2, "R10 ctrl 0x48");
    chk(bus_rdata_o, 32'h48, "R10 ctrl readback");
    wr(4'd0, 32'd4);
    rd(4'd1, "R2 load to counter");
    chk(bus_rdata_o, 32'd4, "R2 value after load");
    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd2, "R10 ctrl masked");
    chk(bus_rdata_o, 32'hC8, "R10 only bits 7,6,3");

    // R4: period N+1
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1'b1, 1'b0);
    chk({31'h0, irq_o[0]}, 32'h0, "R4 no irq after N ticks");
    rd(4'd1, "R4 count at zero");
    step(0, 0, 0, 0, 1'b1, 1'b0);
    chk({31'h0, irq_o[0]}, 32'h1, "R4 irq after N+1 ticks");
    rd(4'd1, "R4 reloaded");
    chk(bus_rdata_o, 32'd4, "R4 reload value");

    // R6 level hold then clear
    step(0, 0, 0, 0, 1'b0, 1'b0);
    chk({31'h0, irq_o[0]}, 32'h1, "R6 irq holds");
    wr(4'd3, 32'h0);
    chk({31'h0, irq_o[0]}, 32'h0, "R6 clear");
    // R6 clear with same-cycle underflow
    wr(4'd0, 32'd0);
    step(1'b1, 1'b1, 4'd3, 32'h5, 1'b1, 1'b0);
    chk({31'h0, irq_o[0]}, 32'h1, "R6 underflow beats clear");
    wr(4'd3, 32'h1);
    chk({31'h0, irq_o[0]}, 32'h0, "R6 later clear");

    // R3 source select and disable
    wr(4'd2, 32'hC0);
    wr(4'd0, 32'd10);
    step(0, 0, 0, 0, 1'b1, 1'b0);
    rd(4'd1, "R3 slow ignored");
    chk(bus_rdata_o, 32'd10, "R3 slow ignored value");
    step(0, 0, 0, 0, 1'b0, 1'b1);
    chk(exp_read(4'd1), 32'd9, "R3 model");
    rd(4'd1, "R3 fast decrements");
    wr(4'd2, 32'h48);
    step(0, 0, 0, 0, 1'b1, 1'b1);
    step(0, 0, 0, 0, 1'b1, 1'b1);
    rd(4'd1, "R3 disabled holds");
    chk(bus_rdata_o, 32'd9, "R3 disabled value");

    // R5, R7 free mode wraps per width
    wr(4'd6, 32'h88);
    wr(4'd4, 32'd0);
    step(0, 0, 0, 0, 1'b1, 1'b0);
    rd(4'd5, "R5 wrap 16");
    chk(bus_rdata_o, 32'h0000_FFFF, "R5 wrap 16 value");
    chk({31'h0, irq_o[1]}, 32'h1, "R6 free-mode irq");
    wr(4'd7, 32'h0);
    wr(4'd10, 32'h88);
    wr(4'd8, 32'd0);
    step(0, 0, 0, 0, 1'b1, 1'b0);
    rd(4'd9, "R7 wrap 32");
    chk(bus_rdata_o, 32'hFFFF_FFFF, "R7 wrap 32 value");
    wr(4'd11, 32'h0);
    wr(4'd0, 32'h1234_5678);
    rd(4'd0, "R7 truncate load");
    chk(bus_rdata_o, 32'h0000_5678, "R7 truncated");
    wr(4'd8, 32'hDEAD_BEEF);
    rd(4'd8, "R7 full 32 load");

    // R8, R9 timestamp
    wr(4'd2, 32'h0); wr(4'd6, 32'h0); wr(4'd10, 32'h0);
    wr(4'd13, 32'h100);
    rd(4'd13, "R8 enable readback");
    chk(bus_rdata_o, 32'h100, "R8 hi word");
    for (int i = 0; i < 7; i++) step(0, 0, 0, 0, 1'b0, 1'b1);
    rd(4'd12, "R8 counts fast");
    chk(bus_rdata_o, 32'd7, "R8 low value");
    step(0, 0, 0, 0, 1'b1, 1'b0);
    step(0, 0, 0, 0, 1'b1, 1'b0);
    rd(4'd12, "R9 slow ignored");
    wr(4'd12, 32'hFFFF);
    rd(4'd12, "R9 low write ignored");
    chk(bus_rdata_o, 32'd7, "R9 low still 7");
    wr(4'd1, 32'h1111);
    rd(4'd1, "R9 value write ignored");
    chk({29'h0, irq_o}, 32'h0, "R9 no stamp irq");
    wr(4'd13, 32'h0);
    rd(4'd12, "R8 disable zeroes");
    chk(bus_rdata_o, 32'h0, "R8 zeroed");
    rd(4'd13, "R8 hi after stop");

    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      a = 4'($urandom % 14);
      d = $urandom;
      if (a < 4'd12 && a % 4 == 0) d = d % 24;
      step(($urandom % 4) == 0, 1'b1, a, d, $urandom % 2, $urandom % 2);
      chk_irq("R6 random irq");
      rd(4'($urandom % 16), "R4 random read");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule